// File: doc/BRIEF.md
# Clock Source Selector Bank with Table Divide

This block drives six consumer clock enables from one shared 32-bit configuration register. Each consumer owns a 5-bit field. The field picks one of seven input strobes: a PLL strobe or one of six frequency-generator strobes. It also picks a small divide from a four-entry table. Each consumer then emits a single-cycle output strobe every time the chosen divide count of selected input strobes has arrived. Every input and output strobe is a one-cycle enable in the single system clock domain.

The divide table is not monotonic. In the base table, index 0 and index 2 both give divide-by-1. A variant input swaps the second divide-by-1 entry for divide-by-3, so a consumer can run at one third of its source rate. A source code of zero switches a consumer off. When a write changes a consumer's field, that consumer restarts its count cleanly.

Top module: `clkdiv_select_bank`

## Requirements
- R1: The register clears to zero on reset. After a write, `rd_data` returns the written value with bits 31:30 forced to zero.
- R2: Consumer i (0..5) is configured by bits 5i+4 .. 5i. Bits 5i+4..5i+2 hold the 3-bit source code. Bits 5i+1..5i hold the 2-bit divide index.
- R3: Source code 0 turns the consumer off. Its output strobe stays low and its count is held at zero.
- R4: Source code 1 selects `src_strb[0]`, the PLL strobe. Codes 2..7 select `src_strb[1]`..`src_strb[6]`, which are frequency generators 0..5.
- R5: With `alt_tab` = 0, divide index 0, 1, 2 and 3 give divide-by-1, 4, 1 and 2 respectively.
- R6: With `alt_tab` = 1, divide index 2 gives divide-by-3. The other three indices are unchanged.
- R7: An enabled consumer with divide d raises its output for one cycle in the cycle after every d-th selected input strobe. The gap is exactly d selected strobes, whatever the spacing of those strobes in time.
- R8: Suppose a write changes a consumer's field. In the following cycle that consumer's output is low and its count restarts from zero. A write that leaves a field unchanged does not disturb that consumer.
- R9: An output strobe is high only in the cycle after a cycle in which at least one input strobe was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_tab | input | 1 | Selects the divide table that offers divide-by-3 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| src_strb | input | 7 | Bit 0 is the PLL strobe; bits 1..6 are frequency generators 0..5 |
| out_strb | output | 6 | Per-consumer output strobe |

## Verification
The bench targets four kinds of fault: the duplicate-entry table slot, the divide-by-3 slot, source codes that are off by one, and the top source code. A wrong table decode produces the wrong number of pulses in a fixed window. A wrong source mapping makes a consumer follow a neighbouring input. The bench also mixes writes that change a field with writes that repeat it, while the strobes arrive at random spacing. A design that restarts the count on every write, or that never restarts it, loses the period relation or leaks a stray pulse after the change. A design that counts time instead of selected strobes breaks the exact-d gap.

// File: rtl/cdsb_pkg.sv
package cdsb_pkg;
    localparam int LANES   = 6;
    localparam int SRC_W   = 3;
    localparam int IDX_W   = 2;
    localparam int FIELD_W = SRC_W + IDX_W;
    localparam int N_SRC   = (1 << SRC_W) - 1;
    localparam int REG_W   = 32;
    localparam int CFG_W   = LANES * FIELD_W;
    localparam int DIV_W   = 3;
    localparam int CNT_W   = 2;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [IDX_W-1:0] idx;
    } lane_cfg_t;

    // divide amount for a table index; alt swaps the repeated /1 for /3
    function automatic logic [DIV_W-1:0] div_of(input logic alt, input logic [IDX_W-1:0] idx);
        logic [DIV_W-1:0] d;
        case (idx)
            2'd0:    d = 3'd1;
            2'd1:    d = 3'd4;
            2'd2:    d = alt ? 3'd3 : 3'd1;
            default: d = 3'd2;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/cdsb_cfg_reg.sv
module cdsb_cfg_reg #(
    parameter int REG_W = 32,
    parameter int CFG_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q,
    output logic [REG_W-1:0] rd_data
);
    localparam int PAD_W = REG_W - CFG_W;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= wr_data[CFG_W-1:0];
    end

    assign rd_data = {{PAD_W{1'b0}}, cfg_q};
endmodule

// File: rtl/cdsb_lane.sv
module cdsb_lane
    import cdsb_pkg::*;
#(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            alt_tab,
    input  lane_cfg_t       cfg_cur,
    input  lane_cfg_t       cfg_new,
    input  logic            upd,
    input  logic [NSRC-1:0] src_strb,
    output logic            strb_o
);
    logic [NSRC:0]      pick_vec;
    logic               sel_strb;
    logic [DIV_W-1:0]   div_amt;
    logic [CNT_W-1:0]   cnt;
    logic               last;
    logic               reconfig;
    logic               live;

    // code 0 lands on a constant-zero slot, so an off lane sees no strobe
    assign pick_vec = {src_strb, 1'b0};
    assign sel_strb = pick_vec[cfg_cur.src];
    assign div_amt  = div_of(alt_tab, cfg_cur.idx);
    assign last     = ({1'b0, cnt} >= (div_amt - 3'd1));
    assign reconfig = upd && (cfg_new != cfg_cur);
    assign live     = (cfg_cur.src != '0);

    always_ff @(posedge clk) begin
        if (rst || reconfig || !live) begin
            cnt    <= '0;
            strb_o <= 1'b0;
        end else if (sel_strb) begin
            if (last) begin
                cnt    <= '0;
                strb_o <= 1'b1;
            end else begin
                cnt    <= cnt + 2'd1;
                strb_o <= 1'b0;
            end
        end else begin
            strb_o <= 1'b0;
        end
    end
endmodule

// File: rtl/clkdiv_select_bank.sv
module clkdiv_select_bank
    import cdsb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alt_tab,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [N_SRC-1:0] src_strb,
    output logic [LANES-1:0] out_strb
);
    logic [CFG_W-1:0] cfg_q;

    cdsb_cfg_reg #(.REG_W(REG_W), .CFG_W(CFG_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_cfg_t cur_c;
        lane_cfg_t new_c;
        assign cur_c = lane_cfg_t'(cfg_q[g*FIELD_W +: FIELD_W]);
        assign new_c = lane_cfg_t'(wr_data[g*FIELD_W +: FIELD_W]);

        cdsb_lane #(.NSRC(N_SRC)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .alt_tab  (alt_tab),
            .cfg_cur  (cur_c),
            .cfg_new  (new_c),
            .upd      (wr_en),
            .src_strb (src_strb),
            .strb_o   (out_strb[g])
        );
    end
endmodule

// File: rtl/clkdiv_select_bank_chk.sv
module clkdiv_select_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic [6:0]  src_strb,
    input logic [5:0]  out_strb
);
    a_r1_top_bits_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:30] == 2'b00);

    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[29:0] == $past(wr_data[29:0]));

    for (genvar g = 0; g < 6; g++) begin : g_chk
        // R3: an off field keeps its output low
        a_r3_off_silent: assert property (@(posedge clk) disable iff (rst)
            (rd_data[g*5+2 +: 3] == 3'd0) |=> !out_strb[g]);

        // R8: a changing write suppresses the lane's next output
        a_r8_change_silent: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_data[g*5 +: 5] != rd_data[g*5 +: 5])) |=> !out_strb[g]);

        // R9: a pulse must follow some input strobe
        a_r9_needs_strobe: assert property (@(posedge clk) disable iff (rst)
            out_strb[g] |-> ($past(src_strb) != 7'd0));
    end
endmodule

bind clkdiv_select_bank clkdiv_select_bank_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .src_strb (src_strb),
    .out_strb (out_strb)
);

// File: tb/clkdiv_select_bank_tb_top.sv
`timescale 1ns/1ps
module clkdiv_select_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alt_tab = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [6:0]  src_strb = '0;
    logic [31:0] rd_data;
    logic [5:0]  out_strb;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clkdiv_select_bank dut_i (
        .clk(clk), .rst(rst), .alt_tab(alt_tab), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .src_strb(src_strb), .out_strb(out_strb)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference
    int unsigned m_cfg = 0;
    int          m_cnt[6];
    bit [5:0]    m_out = '0;

    function automatic int tab(input bit a, input int idx);
        case (idx)
            0: return 1;
            1: return 4;
            2: return a ? 3 : 1;
            default: return 2;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = 0;
            m_out = '0;
            for (int i = 0; i < 6; i++) m_cnt[i] = 0;
        end else begin
            for (int i = 0; i < 6; i++) begin
                int f, nf, s, d;
                f  = int'((m_cfg >> (5*i)) & 31);
                nf = wr_en ? int'((wr_data >> (5*i)) & 31) : f;
                s  = f >> 2;
                d  = tab(alt_tab, f & 3);
                if (nf != f || s == 0) begin
                    m_cnt[i] = 0; m_out[i] = 0;
                end else if (src_strb[s-1]) begin
                    if (m_cnt[i] >= d-1) begin m_cnt[i] = 0; m_out[i] = 1; end
                    else begin m_cnt[i]++; m_out[i] = 0; end
                end else m_out[i] = 0;
            end
            if (wr_en) m_cfg = wr_data & 32'h3FFF_FFFF;
        end
    end

    always @(negedge clk) begin
        if (started && !rst && !done) begin
            chk(rd_data == m_cfg, "R1 R2 read-back", rd_data, m_cfg);
            for (int i = 0; i < 6; i++)
                chk(out_strb[i] == m_out[i], $sformatf("R7 R8 R9 lane %0d", i), out_strb[i], m_out[i]);
        end
    end

    function automatic [31:0] fld(input int i, input int src, input int idx);
        return 32'((src << 2) | idx) << (5*i);
    endfunction

    task automatic wr(input [31:0] v);
        @(negedge clk); wr_en = 1; wr_data = v;
        @(negedge clk); wr_en = 0;
    endtask

    int pc[6];
    task automatic count_win(input bit rewrite);
        repeat (8) @(negedge clk);
        for (int i = 0; i < 6; i++) pc[i] = 0;
        for (int k = 0; k < 24; k++) begin
            @(posedge clk); #1;
            for (int i = 0; i < 6; i++) pc[i] += int'(out_strb[i]);
            if (rewrite && k == 10) begin wr_en = 1; wr_data = rd_data; end
            else wr_en = 0;
        end
        wr_en = 0;
    endtask

    int exp_def[6] = '{24, 6, 24, 12, 0, 24};
    int exp_alt[6] = '{24, 6, 8, 12, 0, 8};

    initial begin
        logic [31:0] cfg_a;
        repeat (3) @(negedge clk);
        rst = 0;
        started = 1;
        @(negedge clk);
        chk(rd_data == 0, "R1 reset value", rd_data, 0);
        chk(out_strb == 0, "R3 reset outputs", out_strb, 0);
        wr(32'hFFFF_FFFF);
        chk(rd_data == 32'h3FFF_FFFF, "R1 top bits read zero", rd_data, 32'h3FFF_FFFF);

        // table decode, all inputs strobing every cycle
        cfg_a = fld(0,1,0) | fld(1,2,1) | fld(2,3,2) | fld(3,4,3) | fld(4,0,1) | fld(5,7,2);
        src_strb = 7'h7F;
        wr(cfg_a);
        count_win(0);
        for (int i = 0; i < 6; i++)
            chk(pc[i] == exp_def[i], $sformatf("R5 R2 R3 default table lane %0d", i), pc[i], exp_def[i]);
        alt_tab = 1;
        count_win(0);
        for (int i = 0; i < 6; i++)
            chk(pc[i] == exp_alt[i], $sformatf("R6 alternate table lane %0d", i), pc[i], exp_alt[i]);
        count_win(1);
        for (int i = 0; i < 6; i++)
            chk(pc[i] == exp_alt[i], $sformatf("R8 same-value rewrite lane %0d", i), pc[i], exp_alt[i]);
        alt_tab = 0;

        // source mapping
        for (int off = 1; off <= 2; off++) begin
            logic [31:0] v;
            v = '0;
            for (int i = 0; i < 6; i++) v |= fld(i, i+off, 0);
            wr(v);
            for (int k = 0; k < 7; k++) begin
                @(negedge clk); src_strb = 7'(1 << k);
                count_win(0);
                for (int i = 0; i < 6; i++) begin
                    int e;
                    e = (i + off - 1 == k) ? 24 : 0;
                    chk(pc[i] == e, $sformatf("R4 code %0d input %0d lane %0d", i+off, k, i), pc[i], e);
                end
            end
        end

        // random strobes and writes, both tables
        for (int seg = 0; seg < 2; seg++) begin
            @(negedge clk); alt_tab = seg[0];
            for (int n = 0; n < 3000; n++) begin
                @(negedge clk);
                src_strb = 7'($urandom);
                wr_en = ($urandom % 12) == 0;
                if ($urandom % 2) wr_data = $urandom;
                else wr_data = rd_data ^ (32'h1F << (5 * ($urandom % 6))) & {32{$urandom % 2 == 0}};
            end
            @(negedge clk); wr_en = 0;
        end

        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule